// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's data cache and keeps the single reservation that a load-linked / store-conditional pair relies on. A load-linked request records the requested address in a link register and marks it live. A later store-conditional is granted only while that reservation is still live and names exactly the same address. A granted store is forwarded toward the cache or memory through a write-enable, and the processor receives a result of 1. A refused store produces a result of 0, and no write or other request leaves the block.

Anything that could break the illusion of atomicity removes the reservation. This includes a context switch, a snooped invalidation of the cache block holding the linked address, and an ordinary store by the same processor to that block. Invalidation and store matching ignore the block-offset bits, and the block size is a parameter. A successful store-conditional also consumes the reservation.

The control is a two-state machine. The states are S_EMPTY (no reservation) and S_LINKED (reservation held). The transitions are T_LINK (a load-linked captures an address, from either state), T_CTX (a context switch empties the monitor), T_SNOOP_KILL (an invalidation hits the linked block), T_STORE_KILL (an own store hits the linked block), T_SC_CONSUME (a granted store-conditional empties the monitor) and T_LL_SQUASH (a load-linked that meets a clearing event in the same cycle leaves the monitor empty).

Top module: `llsc_monitor`

## Requirements
- R1: While reset is held, and right after it, resp_valid, resp_ok and mem_we are 0 and there is no reservation.
- R2: A request with req_kind 1 (store-conditional) in cycle t gives resp_valid=1 in cycle t+1. When the request is granted, resp_ok=1, mem_we=1, mem_addr is the request address and mem_data is the request data. Only store-conditional requests produce resp_valid.
- R3: A store-conditional made with no reservation fails. It gives resp_ok=0, and mem_we stays 0 for any failed store-conditional.
- R4: A store-conditional whose address differs from the linked address in any bit, including the block-offset bits, fails, and the reservation is kept.
- R5: A granted store-conditional clears the reservation, so a second one without a new load-linked fails.
- R6: ctx_switch=1 clears the reservation. A store-conditional in the same cycle as ctx_switch fails.
- R7: inv_valid=1 with inv_addr in the same block as the linked address clears the reservation. Addresses are compared with the low log2(BLOCK_BYTES) bits ignored. An invalidation of another block leaves the reservation alone.
- R8: A store-conditional in the same cycle as an invalidation of the linked block fails.
- R9: An ordinary store (req_kind 2) to the linked block clears the reservation. A store to another block does not.
- R10: A load-linked (req_kind 0) replaces any existing reservation with the new address.
- R11: req_kind 3 is a no-operation. It produces no response and does not change the reservation.
- R12: A load-linked in the same cycle as ctx_switch, or as an invalidation of the block it names, leaves no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_kind | input | 2 | 0 load-linked, 1 store-conditional, 2 ordinary store, 3 no-op |
| req_addr | input | ADDR_W | Request byte address |
| req_data | input | DATA_W | Store-conditional data |
| inv_valid | input | 1 | Snooped invalidation present |
| inv_addr | input | ADDR_W | Address within the invalidated block |
| ctx_switch | input | 1 | Context-switch pulse |
| resp_valid | output | 1 | Store-conditional result present |
| resp_ok | output | 1 | Result: 1 granted, 0 refused |
| mem_we | output | 1 | Write-enable toward cache or memory |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |

## Verification
The bench builds the monitor with ADDR_W=16, DATA_W=32 and BLOCK_BYTES=16, so the low four address bits form the block offset. With that layout, an invalidation or store can land in the linked block at a different word offset, which must clear the reservation, or just past the block boundary, which must not. The same layout lets a store-conditional target the linked block at a different offset and still be refused. Same-cycle collisions of store-conditional or load-linked with context switches and invalidations are driven explicitly.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        REQ_LL   = 2'd0,
        REQ_SC   = 2'd1,
        REQ_ST   = 2'd2,
        REQ_NONE = 2'd3
    } req_kind_e;

    typedef enum logic {
        S_EMPTY  = 1'b0,
        S_LINKED = 1'b1
    } link_state_e;

endpackage

// File: rtl/llsc_block_cmp.sv
module llsc_block_cmp #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_block
);
    localparam int OFFSET_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 0;
    localparam logic [ADDR_W-1:0] TAG_MASK = ~((ADDR_W'(1) << OFFSET_W) - ADDR_W'(1));

    always_comb begin
        same_block = (((addr_a ^ addr_b) & TAG_MASK) == '0);
    end
endmodule

// File: rtl/llsc_link_fsm.sv
module llsc_link_fsm
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_ll,
    input  logic              is_sc,
    input  logic              is_st,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              inv_valid,
    input  logic              hit_inv_link,
    input  logic              hit_inv_req,
    input  logic              hit_req_link,
    input  logic              ctx_switch,
    output link_state_e       state_q,
    output logic [ADDR_W-1:0] link_addr_q
);
    link_state_e       state_d;
    logic [ADDR_W-1:0] link_addr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_EMPTY;
            link_addr_q <= '0;
        end else begin
            state_q     <= state_d;
            link_addr_q <= link_addr_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        link_addr_d = link_addr_q;
        if (ctx_switch) begin
            state_d = S_EMPTY;                       // T_CTX
        end else if (is_ll) begin
            if (inv_valid && hit_inv_req) begin
                state_d = S_EMPTY;                   // T_LL_SQUASH
            end else begin
                state_d     = S_LINKED;              // T_LINK
                link_addr_d = req_addr;
            end
        end else begin
            unique case (state_q)
                S_EMPTY: begin
                    state_d = S_EMPTY;
                end
                S_LINKED: begin
                    if (inv_valid && hit_inv_link) begin
                        state_d = S_EMPTY;           // T_SNOOP_KILL
                    end else if (is_st && hit_req_link) begin
                        state_d = S_EMPTY;           // T_STORE_KILL
                    end else if (is_sc && (req_addr == link_addr_q)) begin
                        state_d = S_EMPTY;           // T_SC_CONSUME
                    end
                end
                default: state_d = S_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_sc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  link_state_e       state_q,
    input  logic [ADDR_W-1:0] link_addr_q,
    input  logic              inv_valid,
    input  logic              hit_inv_link,
    input  logic              ctx_switch,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    logic grant;

    always_comb begin
        grant = is_sc
             && (state_q == S_LINKED)
             && (req_addr == link_addr_q)
             && !ctx_switch
             && !(inv_valid && hit_inv_link);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_ok    <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_data   <= '0;
        end else begin
            resp_valid <= is_sc;
            resp_ok    <= grant;
            mem_we     <= grant;
            if (is_sc) begin
                mem_addr <= req_addr;
                mem_data <= req_data;
            end
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              ctx_switch,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    req_kind_e         kind;
    logic              is_ll, is_sc, is_st;
    logic              hit_inv_link, hit_inv_req, hit_req_link;
    link_state_e       state_q;
    logic [ADDR_W-1:0] link_addr_q;
    logic              link_valid;

    always_comb begin
        kind       = req_kind_e'(req_kind);
        is_ll      = req_valid && (kind == REQ_LL);
        is_sc      = req_valid && (kind == REQ_SC);
        is_st      = req_valid && (kind == REQ_ST);
        link_valid = (state_q == S_LINKED);
    end

    llsc_block_cmp #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_cmp_inv_link (
        .addr_a(inv_addr), .addr_b(link_addr_q), .same_block(hit_inv_link));

    llsc_block_cmp #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_cmp_inv_req (
        .addr_a(inv_addr), .addr_b(req_addr), .same_block(hit_inv_req));

    llsc_block_cmp #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_cmp_req_link (
        .addr_a(req_addr), .addr_b(link_addr_q), .same_block(hit_req_link));

    llsc_link_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .is_ll(is_ll), .is_sc(is_sc), .is_st(is_st),
        .req_addr(req_addr),
        .inv_valid(inv_valid),
        .hit_inv_link(hit_inv_link), .hit_inv_req(hit_inv_req),
        .hit_req_link(hit_req_link),
        .ctx_switch(ctx_switch),
        .state_q(state_q), .link_addr_q(link_addr_q));

    llsc_sc_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_judge (
        .clk(clk), .rst_n(rst_n),
        .is_sc(is_sc), .req_addr(req_addr), .req_data(req_data),
        .state_q(state_q), .link_addr_q(link_addr_q),
        .inv_valid(inv_valid), .hit_inv_link(hit_inv_link),
        .ctx_switch(ctx_switch),
        .resp_valid(resp_valid), .resp_ok(resp_ok),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data));
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ctx_switch,
    input logic              resp_valid,
    input logic              resp_ok,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              link_valid
);
    logic sc_req;
    assign sc_req = req_valid && (req_kind == 2'd1);

    AST_RESP_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> resp_valid);                                        // R2
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> !resp_valid);                                      // R11
    AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> (mem_addr == $past(req_addr)));                     // R2
    AST_WE_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (resp_valid && resp_ok));                           // R3
    AST_OK_HAS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ok) |-> mem_we);                           // R2
    AST_EMPTY_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !link_valid) |=> !resp_ok);                         // R3
    AST_GRANT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> !link_valid);                                      // R5
    AST_CTX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> !link_valid);                                   // R6
    AST_CTX_SC_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_switch && sc_req) |=> !resp_ok);                          // R6
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .ctx_switch(ctx_switch), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .mem_we(mem_we), .mem_addr(mem_addr),
    .link_valid(link_valid));

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int BLOCK_BYTES = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'd3;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              inv_valid = 1'b0;
    logic [ADDR_W-1:0] inv_addr = '0;
    logic              ctx_switch = 1'b0;
    logic              resp_valid, resp_ok, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit                exp_ok[$];
    logic [ADDR_W-1:0] exp_addr[$];
    logic [DATA_W-1:0] exp_data[$];
    string             exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .ctx_switch(ctx_switch), .resp_valid(resp_valid),
        .resp_ok(resp_ok), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data));

    task automatic check(bit cond, string req, string what, longint act, longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one request per cycle, optional same-cycle invalidation / context switch
    task automatic drive(input logic [1:0] kind, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit iv,
                         input logic [ADDR_W-1:0] ia, input bit cs,
                         input bit ok_exp, input string tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_kind   = kind;
        req_addr   = a;
        req_data   = d;
        inv_valid  = iv;
        inv_addr   = ia;
        ctx_switch = cs;
        if (kind == 2'd1) begin
            exp_ok.push_back(ok_exp);
            exp_addr.push_back(a);
            exp_data.push_back(d);
            exp_tag.push_back(tag);
        end
        @(negedge clk);
        req_valid  = 1'b0;
        req_kind   = 2'd3;
        inv_valid  = 1'b0;
        ctx_switch = 1'b0;
    endtask

    task automatic ll(input logic [ADDR_W-1:0] a);
        drive(2'd0, a, '0, 1'b0, '0, 1'b0, 1'b0, "");
    endtask

    task automatic sc(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      input bit ok_exp, input string tag);
        drive(2'd1, a, d, 1'b0, '0, 1'b0, ok_exp, tag);
    endtask

    task automatic inv(input logic [ADDR_W-1:0] ia);
        @(negedge clk);
        inv_valid = 1'b1;
        inv_addr  = ia;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (resp_valid) begin
                if (exp_ok.size() == 0) begin
                    check(1'b0, "R11", "unexpected response", 1, 0);
                end else begin
                    automatic bit                ok = exp_ok.pop_front();
                    automatic logic [ADDR_W-1:0] ea = exp_addr.pop_front();
                    automatic logic [DATA_W-1:0] ed = exp_data.pop_front();
                    automatic string             tg = exp_tag.pop_front();
                    check(resp_ok == ok, tg, "resp_ok", resp_ok, ok);
                    check(mem_we == ok, tg, "mem_we", mem_we, ok);
                    if (ok) begin
                        check(mem_addr == ea, tg, "mem_addr", mem_addr, ea);
                        check(mem_data == ed, tg, "mem_data", mem_data, ed);
                    end
                end
            end else if (mem_we) begin
                check(1'b0, "R3", "write without result", 1, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        check(resp_ok == 1'b0, "R1", "resp_ok in reset", resp_ok, 0);
        check(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);

        sc(16'h0100, 32'h1111_0000, 1'b0, "R1 no reservation after reset");
        sc(16'h0100, 32'h1111_0001, 1'b0, "R3");
        ll(16'h0100);
        sc(16'h0100, 32'hA5A5_0001, 1'b1, "R2");
        sc(16'h0100, 32'hA5A5_0002, 1'b0, "R5");

        ll(16'h0200);
        sc(16'h0204, 32'h2222_0001, 1'b0, "R4 offset mismatch");
        sc(16'h0200, 32'h2222_0002, 1'b1, "R4 reservation kept");

        ll(16'h0300);
        drive(2'd3, 16'h0000, '0, 1'b0, '0, 1'b1, 1'b0, "");
        sc(16'h0300, 32'h3333_0001, 1'b0, "R6 after ctx");
        ll(16'h0300);
        drive(2'd1, 16'h0300, 32'h3333_0002, 1'b0, '0, 1'b1, 1'b0, "R6 same-cycle ctx");

        ll(16'h0400);
        inv(16'h040C);
        sc(16'h0400, 32'h4444_0001, 1'b0, "R7 same block");
        ll(16'h0400);
        inv(16'h0410);
        sc(16'h0400, 32'h4444_0002, 1'b1, "R7 other block");

        ll(16'h0500);
        drive(2'd1, 16'h0500, 32'h5555_0001, 1'b1, 16'h0508, 1'b0, 1'b0, "R8");

        ll(16'h0600);
        drive(2'd2, 16'h0604, 32'h0, 1'b0, '0, 1'b0, 1'b0, "");
        sc(16'h0600, 32'h6666_0001, 1'b0, "R9 own store same block");
        ll(16'h0600);
        drive(2'd2, 16'h0700, 32'h0, 1'b0, '0, 1'b0, 1'b0, "");
        sc(16'h0600, 32'h6666_0002, 1'b1, "R9 own store other block");

        ll(16'h0800);
        ll(16'h0900);
        sc(16'h0800, 32'h8888_0001, 1'b0, "R10 old address");
        sc(16'h0900, 32'h8888_0002, 1'b1, "R10 new address");

        drive(2'd0, 16'h0A00, '0, 1'b0, '0, 1'b1, 1'b0, "");
        sc(16'h0A00, 32'hAAAA_0001, 1'b0, "R12 ll with ctx");
        drive(2'd0, 16'h0A00, '0, 1'b1, 16'h0A04, 1'b0, 1'b0, "");
        sc(16'h0A00, 32'hAAAA_0002, 1'b0, "R12 ll with inv");
        drive(2'd0, 16'h0A00, '0, 1'b1, 16'h0B00, 1'b0, 1'b0, "");
        sc(16'h0A00, 32'hAAAA_0003, 1'b1, "R12 ll with other inv");

        ll(16'h0C00);
        drive(2'd3, 16'h0C00, 32'h0, 1'b0, '0, 1'b0, 1'b0, "");
        sc(16'h0C00, 32'hCCCC_0001, 1'b1, "R11 no-op keeps reservation");

        repeat (3) @(negedge clk);
        check(exp_ok.size() == 0, "R2", "pending responses", exp_ok.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule